// File: doc/BRIEF.md
# Ready-Latency Bridging Receive Adapter

The adapter connects a packet source that obeys a two-cycle ready latency to a consumer that uses a plain valid/ready handshake with no latency. A beat from the source carries the data word, start and end flags (two bits each) and a two-bit empty code. A beat that arrives with `src_valid` high is always written into a small skid store. Beats are read out of that store in arrival order. The consumer never sees the empty code. Instead it gets a mask with one bit per 64-bit word, where a set bit marks a word that holds payload.

The ready toward the source is registered and comes from a three-state controller. `ST_HOLD` is the state entered under reset. It always moves on after one cycle: to `ST_OPEN` if the store has room, otherwise to `ST_SHUT`. `ST_OPEN` drives ready high and moves to `ST_SHUT` when the worst-case occupancy would exceed the depth. That worst case is the current fill, plus the beats already granted but not yet arrived, plus one more. `ST_SHUT` drives ready low and moves back to `ST_OPEN` once that sum fits again.

The mask decode has three variants. The 256-bit single-packet variant reads the empty code as a count of unused words at the top. The 256-bit dual-packet variant treats each end/empty bit as belonging to one 128-bit half. The 128-bit variant has two words.

Top module: `rl_rx_adapter`

## Requirements
- R1: The source may present a beat in cycle n+2 only if `src_ready` was high in cycle n. `src_ready` never opens a window earlier than that.
- R2: Every beat that arrives with `src_valid` high is delivered exactly once. This includes the up to two beats that still arrive after `src_ready` has fallen.
- R3: The store never holds more than DEPTH beats. If the consumer stalls while the source sends at full rate, exactly DEPTH beats are held and `src_ready` stays low.
- R4: Beats leave in arrival order, with data, start flags and end flags unchanged.
- R5: While `dst_valid` is high and `dst_ready` is low, `dst_valid`, the data, the flags and the mask do not change in the next cycle.
- R6: 256-bit single-packet mode: when `src_eop[0]` is 1, the mask has its lowest 4-E bits set, where E is `src_empty` read as 0..3. For example, E=2 gives mask 0011.
- R7: 256-bit dual-packet mode: bit 0 of end/empty refers to data bits 127:0 and bit 1 refers to bits 255:128. Mask bit 1 is cleared when both `src_eop[0]` and `src_empty[0]` are set. Mask bit 3 is cleared when both `src_eop[1]` and `src_empty[1]` are set. All other mask bits are set.
- R8: 128-bit mode: the mask is 01 when both `src_eop[0]` and `src_empty[0]` are set, and 11 otherwise.
- R9: When a beat has no end flag set, its mask is all ones whatever the empty code is.
- R10: Synchronous active-high reset empties the store and drives `dst_valid` low. `src_ready` is low in the first cycle in which reset is sampled low, and goes high in the cycle after it.
- R11: While the consumer is always ready and the source sends at every allowed cycle, `src_ready` stays high, so one beat per cycle flows through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 1 | Beat present from the source |
| src_data | input | DATA_W | Beat data |
| src_sop | input | 2 | Start-of-packet flags |
| src_eop | input | 2 | End-of-packet flags |
| src_empty | input | 2 | Empty code |
| src_ready | output | 1 | Ready toward the source, two-cycle latency |
| dst_valid | output | 1 | Beat available to the consumer |
| dst_ready | input | 1 | Consumer accepts the beat |
| dst_data | output | DATA_W | Delivered data |
| dst_sop | output | 2 | Delivered start flags |
| dst_eop | output | 2 | Delivered end flags |
| dst_qmask | output | DATA_W/64 | Valid mask, one bit per 64-bit word |

## Verification
The bench fills the store by stalling the consumer while the source sends at every permitted cycle. A controller that forgot one of the two beats in flight would lose one, and the exact fill count and the final delivered total would expose it. A controller that throttled too early would show up as a dip in `src_ready` during the full-rate phase. Long runs with random stalls check every held beat for stability and check every delivered beat for order. The empty/end combinations cycle through all sixteen values, so a decode that used the wrong half, shifted in the wrong direction, or masked beats with no end flag would give a wrong mask in one of the three configurations.

// File: rtl/rlrx_pkg.sv
package rlrx_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_OPEN = 2'd1,
        ST_SHUT = 2'd2
    } rdy_state_e;

    localparam int unsigned QWORD_W = 64;

endpackage

// File: rtl/rlrx_qmask.sv
module rlrx_qmask #(
    parameter int unsigned QW   = 4,
    parameter bit          DUAL = 1'b0
) (
    input  logic [1:0]    eop,
    input  logic [1:0]    empty,
    output logic [QW-1:0] qmask
);

    generate
        if (QW == 2) begin : g_narrow
            logic unused_hi;
            assign unused_hi = eop[1] ^ empty[1];
            always_comb qmask = (eop[0] && empty[0]) ? QW'(2'b01) : '1;
        end else if (DUAL) begin : g_dual
            always_comb begin
                qmask = '1;
                if (eop[0] && empty[0]) qmask[1]    = 1'b0;
                if (eop[1] && empty[1]) qmask[QW-1] = 1'b0;
            end
        end else begin : g_single
            logic unused_hi;
            assign unused_hi = eop[1];
            always_comb qmask = eop[0] ? ({QW{1'b1}} >> empty) : '1;
        end
    endgenerate

endmodule

// File: rtl/rlrx_skid_fifo.sv
module rlrx_skid_fifo #(
    parameter int unsigned W     = 264,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CNT_W = 3,
    parameter int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_entry,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic [W-1:0]     rd_entry,
    output logic [CNT_W-1:0] occ_next
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_rd;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        rd_valid = (count != '0);
        do_rd    = rd_valid && rd_ready;
        rd_entry = mem[rd_ptr];
        occ_next = count + CNT_W'(wr_en) - CNT_W'(do_rd);
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            count <= occ_next;
        end
    end

    // R3: a write never lands on a full store
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (count < CNT_W'(DEPTH)))
        else $error("store overflow");

    // R5: a stalled beat is held unchanged
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_entry)))
        else $error("stalled beat changed");

endmodule

// File: rtl/rlrx_ready_ctl.sv
module rlrx_ready_ctl
    import rlrx_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] occ_next,
    input  logic             in_valid,
    output logic             src_ready
);

    rdy_state_e state_q, state_d;
    logic       rdy_d1, rdy_d2, room, rst_q;

    // worst case: current fill + beats granted but not yet arrived + one more
    always_comb
        room = (32'(occ_next) + 32'(src_ready) + 32'(rdy_d1) + 32'd1) <= DEPTH;

    always_comb begin
        unique case (state_q)
            ST_HOLD: state_d = room ? ST_OPEN : ST_SHUT;
            ST_OPEN: state_d = room ? ST_OPEN : ST_SHUT;
            ST_SHUT: state_d = room ? ST_OPEN : ST_SHUT;
            default: state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_OPEN: src_ready = 1'b1;
            default: src_ready = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HOLD;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_d1 <= 1'b0;
            rdy_d2 <= 1'b0;
        end else begin
            rdy_d1 <= src_ready;
            rdy_d2 <= rdy_d1;
        end
    end

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q && !rst)
            p_rdy_low_r10: assert (!src_ready) else $error("ready high right after reset");
    end

    // R1: a beat only arrives two cycles after ready was granted
    p_window_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> rdy_d2)
        else $error("beat outside ready window");

endmodule

// File: rtl/rl_rx_adapter.sv
module rl_rx_adapter
    import rlrx_pkg::*;
#(
    parameter int unsigned DATA_W   = 256,
    parameter int unsigned DEPTH    = 4,
    parameter bit          DUAL_PKT = 1'b0,
    localparam int unsigned QW      = DATA_W / QWORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic [1:0]        src_sop,
    input  logic [1:0]        src_eop,
    input  logic [1:0]        src_empty,
    output logic              src_ready,
    output logic              dst_valid,
    input  logic              dst_ready,
    output logic [DATA_W-1:0] dst_data,
    output logic [1:0]        dst_sop,
    output logic [1:0]        dst_eop,
    output logic [QW-1:0]     dst_qmask
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned ENT_W = DATA_W + 4 + QW;

    logic [QW-1:0]    in_mask;
    logic [ENT_W-1:0] wr_entry, rd_entry;
    logic [CNT_W-1:0] occ_next;

    rlrx_qmask #(.QW(QW), .DUAL(DUAL_PKT)) u_mask (
        .eop   (src_eop),
        .empty (src_empty),
        .qmask (in_mask)
    );

    assign wr_entry = {src_data, src_sop, src_eop, in_mask};

    rlrx_skid_fifo #(.W(ENT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (src_valid),
        .wr_entry (wr_entry),
        .rd_ready (dst_ready),
        .rd_valid (dst_valid),
        .rd_entry (rd_entry),
        .occ_next (occ_next)
    );

    rlrx_ready_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .occ_next  (occ_next),
        .in_valid  (src_valid),
        .src_ready (src_ready)
    );

    assign {dst_data, dst_sop, dst_eop, dst_qmask} = rd_entry;

    // R9: beats without an end flag carry a full mask
    p_full_mask_r9: assert property (@(posedge clk) disable iff (rst)
        (dst_valid && dst_eop == 2'b00) |-> (&dst_qmask))
        else $error("partial mask on non-final beat");

endmodule

// File: tb/sim_rl_rx_adapter.sv
module sim_rl_rx_adapter;

    localparam int unsigned DEPTH = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, s_valid, dst_ready;
    logic [31:0] s_seq;
    wire  [1:0]  s_sop   = s_seq[6:5];
    wire  [1:0]  s_eop   = s_seq[2:1];
    wire  [1:0]  s_empty = s_seq[4:3];

    logic         rdy0, rdy1, rdy2, v0, v1, v2;
    logic [255:0] d0, d1;
    logic [127:0] d2;
    logic [1:0]   sop0, sop1, sop2, eop0, eop1, eop2;
    logic [3:0]   m0, m1;
    logic [1:0]   m2;

    rl_rx_adapter #(.DATA_W(256), .DEPTH(DEPTH), .DUAL_PKT(1'b0)) u0 (
        .clk(clk), .rst(rst), .src_valid(s_valid), .src_data({8{s_seq}}),
        .src_sop(s_sop), .src_eop(s_eop), .src_empty(s_empty), .src_ready(rdy0),
        .dst_valid(v0), .dst_ready(dst_ready), .dst_data(d0), .dst_sop(sop0),
        .dst_eop(eop0), .dst_qmask(m0));

    rl_rx_adapter #(.DATA_W(256), .DEPTH(DEPTH), .DUAL_PKT(1'b1)) u1 (
        .clk(clk), .rst(rst), .src_valid(s_valid), .src_data({8{s_seq}}),
        .src_sop(s_sop), .src_eop(s_eop), .src_empty(s_empty), .src_ready(rdy1),
        .dst_valid(v1), .dst_ready(dst_ready), .dst_data(d1), .dst_sop(sop1),
        .dst_eop(eop1), .dst_qmask(m1));

    rl_rx_adapter #(.DATA_W(128), .DEPTH(DEPTH), .DUAL_PKT(1'b0)) u2 (
        .clk(clk), .rst(rst), .src_valid(s_valid), .src_data({4{s_seq}}),
        .src_sop(s_sop), .src_eop(s_eop), .src_empty(s_empty), .src_ready(rdy2),
        .dst_valid(v2), .dst_ready(dst_ready), .dst_data(d2), .dst_sop(sop2),
        .dst_eop(eop2), .dst_qmask(m2));

    int          checks = 0, fails = 0, cycles = 0;
    int          rdy_mode = 0, src_mode = 0;
    bit          chk_thru = 0, rh1 = 0, rh2 = 0;
    logic [31:0] next_send = 0, rx0 = 0, rx1 = 0, rx2 = 0;
    logic [15:0] lf = 16'hACE1;
    logic        p_v = 0, p_r = 0;
    logic [255:0] p_d;
    logic [1:0]  p_sop, p_eop;
    logic [3:0]  p_m;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] em_single(input logic [31:0] s);
        if (!s[1]) return 4'hF;
        return 4'((5'd1 << (3'd4 - {1'b0, s[4:3]})) - 5'd1);
    endfunction

    function automatic logic [3:0] em_dual(input logic [31:0] s);
        logic [3:0] m = 4'hF;
        if (s[1] && s[3]) m = m & 4'b1101;
        if (s[2] && s[4]) m = m & 4'b0111;
        return m;
    endfunction

    function automatic logic [1:0] em_narrow(input logic [31:0] s);
        return (s[1] && s[3]) ? 2'b01 : 2'b11;
    endfunction

    task automatic step();
        bit want;
        @(negedge clk);
        if (p_v && !p_r)
            check(v0 && d0 == p_d && sop0 == p_sop && eop0 == p_eop && m0 == p_m,
                  "R5", "held beat", {v0, d0[31:0]}, {1'b1, p_d[31:0]});
        unique case (rdy_mode)
            0: dst_ready = 1'b1;
            1: dst_ready = 1'b0;
            2: dst_ready = lf[0];
            3: dst_ready = lf[1] & lf[2];
            default: dst_ready = (lf[5:3] != 3'd0);
        endcase
        if (v0 && dst_ready) begin
            check(d0 == {8{rx0}} && sop0 == rx0[6:5] && eop0 == rx0[2:1],
                  "R4", "single order/data", d0, {8{rx0}});
            check(m0 == em_single(rx0), rx0[1] ? "R6" : "R9", "single mask",
                  256'(m0), 256'(em_single(rx0)));
            rx0++;
        end
        if (v1 && dst_ready) begin
            check(d1 == {8{rx1}} && sop1 == rx1[6:5] && eop1 == rx1[2:1],
                  "R4", "dual order/data", d1, {8{rx1}});
            check(m1 == em_dual(rx1), (rx1[2:1] != 0) ? "R7" : "R9", "dual mask",
                  256'(m1), 256'(em_dual(rx1)));
            rx1++;
        end
        if (v2 && dst_ready) begin
            check(d2 == {4{rx2}} && sop2 == rx2[6:5] && eop2 == rx2[2:1],
                  "R4", "narrow order/data", 256'(d2), 256'({4{rx2}}));
            check(m2 == em_narrow(rx2), rx2[1] ? "R8" : "R9", "narrow mask",
                  256'(m2), 256'(em_narrow(rx2)));
            rx2++;
        end
        p_v = v0; p_r = dst_ready; p_d = d0; p_sop = sop0; p_eop = eop0; p_m = m0;
        want = (src_mode == 0) ? 1'b1 : (src_mode == 1) ? (lf[7] | lf[8]) : 1'b0;
        if (rh2 && want) begin
            s_valid = 1'b1;
            s_seq   = next_send;
            next_send++;
        end else begin
            s_valid = 1'b0;
        end
        rh2 = rh1;
        rh1 = rdy0;
        if (chk_thru) check(rdy0 == 1'b1, "R11", "ready at full rate", 256'(rdy0), 256'(1));
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog: actual %0d cycles expected below 20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; dst_ready = 1'b0; s_valid = 1'b0; s_seq = '0;
        repeat (3) @(negedge clk);
        check(!rdy0 && !v0 && !v1 && !v2, "R10", "during reset",
              256'({rdy0, v0, v1, v2}), 256'(0));
        rst = 1'b0;
        #1;
        check(!rdy0 && !rdy1 && !rdy2, "R10", "first cycle after reset",
              256'({rdy0, rdy1, rdy2}), 256'(0));

        rdy_mode = 0; src_mode = 0; chk_thru = 1;
        repeat (60) step();
        chk_thru = 0;

        rdy_mode = 1;
        repeat (20) step();
        check(next_send - rx0 == DEPTH, "R3", "beats held after stall",
              256'(next_send - rx0), 256'(DEPTH));
        check(!rdy0, "R3", "ready low when full", 256'(rdy0), 256'(0));
        check(v0 && v1 && v2, "R5", "valid held during stall",
              256'({v0, v1, v2}), 256'(7));

        for (int blk = 0; blk < 6; blk++) begin
            unique case (blk)
                0: rdy_mode = 2;
                1: rdy_mode = 3;
                2: rdy_mode = 4;
                3: rdy_mode = 0;
                4: rdy_mode = 1;
                default: rdy_mode = 2;
            endcase
            src_mode = blk % 2;
            repeat (250) step();
        end

        rdy_mode = 0; src_mode = 2;
        repeat (30) step();
        check(rx0 == next_send, "R2", "single delivered total", 256'(rx0), 256'(next_send));
        check(rx1 == next_send, "R2", "dual delivered total", 256'(rx1), 256'(next_send));
        check(rx2 == next_send, "R2", "narrow delivered total", 256'(rx2), 256'(next_send));
        check(!v0 && rdy0, "R3", "drained and reopened", 256'({v0, rdy0}), 256'(1));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule